// File: doc/BRIEF.md
# Split-Permission Direct-Mapped Translation Cache

This block caches recent virtual-to-physical page translations for a processor's memory pipeline. It has a single direct-mapped set of entries, selected by the low bits of the virtual page number. Each entry has three independent tags, one for instruction fetch, one for data load and one for data store. All three tags share one physical page number. A translation that was installed for one kind of access grants nothing to the other two kinds. A lookup is purely combinational: it compares the tag of the requested kind and, on a match, joins the cached physical page number to the page offset of the request.

Translations are installed by a refill request, which comes from an external page walker once a miss has been resolved. The refill always overwrites the shared physical page number at its index. It writes the tag of its own access kind only when the walker reports that the whole page lies in a region with uniform protection. Any tag at that index, of any kind, that names a different page is discarded, because the shared data slot no longer belongs to that page. A refill can mark its tag for trigger checking. A marked fetch tag never hits, while marked load and store tags still hit. While the modify-privilege override is active, refills are dropped. A flush strobe, or reset, discards every tag. When a flush and a refill arrive in the same cycle, the flush wins.

Top module: `split_tlb`

## Requirements
- R1: After reset, every lookup misses, including one for the all-ones virtual page number. A miss drives `lk_paddr` to zero.
- R2: After a refill with `rf_uniform`=1, a lookup of the same kind on the same page hits. Its `lk_paddr` is the refill's physical page number joined to the lookup's own 12-bit page offset.
- R3: The access kind is encoded as 0 for fetch, 1 for load and 2 for store. A refill of one kind does not make lookups of the other two kinds hit.
- R4: The index is the virtual page number modulo the entry count (256). A lookup of a different page that maps to the same index misses.
- R5: A refill invalidates the tags of other kinds at its index that hold a different page. Tags at that index that hold the same page are kept.
- R6: A refill with `rf_uniform`=0 writes no tag, but it still replaces the shared physical page number at its index. Other-kind tags on the same page then translate to the new physical page.
- R7: With `rf_trig`=1, the installed fetch tag never hits. Load and store tags installed with `rf_trig`=1 hit normally.
- R8: While `mod_priv` is high, a refill changes neither tags nor data.
- R9: `flush` invalidates every tag of all three kinds. A refill presented in the same cycle as `flush` is discarded.
- R10: Kind code 3 is reserved. A lookup with kind 3 always misses, and a refill with kind 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; discards all tags |
| lk_vaddr | input | VADDR_W (32) | Lookup virtual address |
| lk_kind | input | 2 | Lookup access kind: 0 fetch, 1 load, 2 store, 3 reserved |
| lk_hit | output | 1 | Lookup hit, combinational |
| lk_paddr | output | PADDR_W (34) | Translated physical address on hit, zero on miss |
| rf_valid | input | 1 | Refill request strobe |
| rf_vaddr | input | VADDR_W (32) | Refill virtual address |
| rf_paddr | input | PADDR_W (34) | Refill physical address |
| rf_kind | input | 2 | Refill access kind, encoded as for lookups |
| rf_uniform | input | 1 | The page lies in one uniform protection region |
| rf_trig | input | 1 | Mark the installed tag for trigger checking |
| mod_priv | input | 1 | Modify-privilege override is active; blocks refills |
| flush | input | 1 | Invalidate every tag |

## Verification
Two pairs of functions can fall in the same cycle. A flush can arrive together with a refill, and the override can be active while a refill is presented. The bench provokes the first by raising `flush` and `rf_valid` on the same edge. It then judges the outcome at the lookup port: both the refilled page and previously valid pages must miss. It provokes the second by refilling while `mod_priv` is high, at an index that already holds a live translation. The old translation must still hit with its old physical page, and the new page must miss. Index aliasing is covered as well, by refilling a second page at an occupied index, which also exercises the cross-kind eviction rule.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    localparam int NUM_KINDS       = 3;
    localparam int DEF_VADDR_W     = 32;
    localparam int DEF_PADDR_W     = 34;
    localparam int DEF_PAGE_SHIFT  = 12;
    localparam int DEF_ENTRIES     = 256;

    // Kinds that may own a tag array
    function automatic logic kind_real(input logic [1:0] k);
        return k != ACC_NONE;
    endfunction

endpackage

// File: rtl/tlb_tag_bank.sv
module tlb_tag_bank #(
    parameter int VPN_W       = 20,
    parameter int ENTRIES     = 256,
    parameter bit STRICT_FLAG = 1'b0,
    localparam int IDX_W      = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             wr_own,
    input  logic             wr_flag,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [VPN_W-1:0] rd_vpn,
    output logic             rd_hit
);
    // Stored tag layout: {pad, trigger flag, vpn}. A live tag has pad = 0,
    // so the all-ones invalid pattern never matches any page.
    localparam int TAG_W  = VPN_W + 2;
    localparam int FLAG_B = VPN_W;

    logic [TAG_W-1:0] tags [ENTRIES];
    logic [TAG_W-1:0] wr_old;
    logic [TAG_W-1:0] wr_plain;
    logic [TAG_W-1:0] rd_tag;
    logic [TAG_W-1:0] rd_plain;
    logic [TAG_W-1:0] rd_want;

    always_comb begin
        wr_old            = tags[wr_idx];
        wr_plain          = wr_old;
        wr_plain[FLAG_B]  = 1'b0;
        rd_tag            = tags[rd_idx];
        rd_plain          = rd_tag;
        rd_plain[FLAG_B]  = 1'b0;
        rd_want           = {2'b00, rd_vpn};
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tags[i] <= '1;
            end
        end else if (wr_en) begin
            if (wr_own) begin
                tags[wr_idx] <= {1'b0, wr_flag, wr_vpn};
            end else if (wr_plain != {2'b00, wr_vpn}) begin
                tags[wr_idx] <= '1;
            end
        end
    end

    generate
        if (STRICT_FLAG) begin : g_strict
            assign rd_hit = (rd_tag == rd_want);
        end else begin : g_masked
            assign rd_hit = (rd_plain == rd_want);
        end
    endgenerate

endmodule

// File: rtl/tlb_data_bank.sv
module tlb_data_bank #(
    parameter int PPN_W   = 22,
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PPN_W-1:0] rd_ppn
);
    logic [PPN_W-1:0] ppns [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ppns[i] <= '0;
            end
        end else if (wr_en) begin
            ppns[wr_idx] <= wr_ppn;
        end
    end

    assign rd_ppn = ppns[rd_idx];

endmodule

// File: rtl/split_tlb.sv
module split_tlb
    import tlb_pkg::*;
#(
    parameter int VADDR_W    = DEF_VADDR_W,
    parameter int PADDR_W    = DEF_PADDR_W,
    parameter int PAGE_SHIFT = DEF_PAGE_SHIFT,
    parameter int ENTRIES    = DEF_ENTRIES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VADDR_W-1:0] lk_vaddr,
    input  logic [1:0]         lk_kind,
    output logic               lk_hit,
    output logic [PADDR_W-1:0] lk_paddr,
    input  logic               rf_valid,
    input  logic [VADDR_W-1:0] rf_vaddr,
    input  logic [PADDR_W-1:0] rf_paddr,
    input  logic [1:0]         rf_kind,
    input  logic               rf_uniform,
    input  logic               rf_trig,
    input  logic               mod_priv,
    input  logic               flush
);
    localparam int VPN_W = VADDR_W - PAGE_SHIFT;
    localparam int PPN_W = PADDR_W - PAGE_SHIFT;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [VPN_W-1:0]      lk_vpn, rf_vpn;
    logic [IDX_W-1:0]      lk_idx, rf_idx;
    logic [PPN_W-1:0]      rf_ppn, hit_ppn;
    logic                  rf_take;
    logic [NUM_KINDS-1:0]  kind_hit;
    logic                  sel_hit;

    assign lk_vpn  = lk_vaddr[VADDR_W-1:PAGE_SHIFT];
    assign rf_vpn  = rf_vaddr[VADDR_W-1:PAGE_SHIFT];
    assign lk_idx  = lk_vpn[IDX_W-1:0];
    assign rf_idx  = rf_vpn[IDX_W-1:0];
    assign rf_ppn  = rf_paddr[PADDR_W-1:PAGE_SHIFT];

    // Flush and the privilege override both veto an install
    assign rf_take = rf_valid && !mod_priv && !flush && kind_real(rf_kind);

    generate
        for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
            tlb_tag_bank #(
                .VPN_W       (VPN_W),
                .ENTRIES     (ENTRIES),
                .STRICT_FLAG (k == int'(ACC_FETCH))
            ) u_tags (
                .clk     (clk),
                .rst     (rst),
                .flush   (flush),
                .wr_en   (rf_take),
                .wr_own  (rf_uniform && (rf_kind == 2'(k))),
                .wr_flag (rf_trig),
                .wr_idx  (rf_idx),
                .wr_vpn  (rf_vpn),
                .rd_idx  (lk_idx),
                .rd_vpn  (lk_vpn),
                .rd_hit  (kind_hit[k])
            );
        end
    endgenerate

    tlb_data_bank #(
        .PPN_W   (PPN_W),
        .ENTRIES (ENTRIES)
    ) u_data (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (rf_take),
        .wr_idx (rf_idx),
        .wr_ppn (rf_ppn),
        .rd_idx (lk_idx),
        .rd_ppn (hit_ppn)
    );

    always_comb begin
        case (lk_kind)
            ACC_FETCH: sel_hit = kind_hit[0];
            ACC_LOAD:  sel_hit = kind_hit[1];
            ACC_STORE: sel_hit = kind_hit[2];
            default:   sel_hit = 1'b0;
        endcase
    end

    assign lk_hit   = sel_hit;
    assign lk_paddr = sel_hit ? {hit_ppn, lk_vaddr[PAGE_SHIFT-1:0]} : '0;

endmodule

// File: rtl/split_tlb_chk.sv
module split_tlb_chk #(
    parameter int VADDR_W    = 32,
    parameter int PADDR_W    = 34,
    parameter int PAGE_SHIFT = 12
) (
    input logic               clk,
    input logic               rst,
    input logic [VADDR_W-1:0] lk_vaddr,
    input logic [1:0]         lk_kind,
    input logic               lk_hit,
    input logic [PADDR_W-1:0] lk_paddr,
    input logic               rf_valid,
    input logic [VADDR_W-1:0] rf_vaddr,
    input logic [1:0]         rf_kind,
    input logic               rf_uniform,
    input logic               rf_trig,
    input logic               mod_priv,
    input logic               flush
);
    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);

    // R10
    reserved_kind_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_kind == 2'd3) |-> !lk_hit);

    // R2
    offset_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_paddr[PAGE_SHIFT-1:0] == lk_vaddr[PAGE_SHIFT-1:0]));

    // R2
    refill_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_valid && !mod_priv && !flush && rf_uniform && (rf_kind == 2'd1 || rf_kind == 2'd2))
        |=> (lk_kind != $past(rf_kind)
             || lk_vaddr[VADDR_W-1:PAGE_SHIFT] != $past(rf_vaddr[VADDR_W-1:PAGE_SHIFT])
             || lk_hit));

    // R8
    override_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (mod_priv && !flush)
        |=> (!$stable(lk_vaddr) || !$stable(lk_kind)
             || ($stable(lk_hit) && $stable(lk_paddr))));

    // R1
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_paddr == '0));

endmodule

bind split_tlb split_tlb_chk #(
    .VADDR_W    (VADDR_W),
    .PADDR_W    (PADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_vaddr   (lk_vaddr),
    .lk_kind    (lk_kind),
    .lk_hit     (lk_hit),
    .lk_paddr   (lk_paddr),
    .rf_valid   (rf_valid),
    .rf_vaddr   (rf_vaddr),
    .rf_kind    (rf_kind),
    .rf_uniform (rf_uniform),
    .rf_trig    (rf_trig),
    .mod_priv   (mod_priv),
    .flush      (flush)
);

// File: tb/split_tlb_test.sv
module split_tlb_test;
    localparam int CLK_PERIOD = 10;
    localparam int VA_W = 32;
    localparam int PA_W = 34;

    localparam logic [1:0] KF = 2'd0;
    localparam logic [1:0] KL = 2'd1;
    localparam logic [1:0] KS = 2'd2;
    localparam logic [1:0] KX = 2'd3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [VA_W-1:0] lk_vaddr = '0;
    logic [1:0]      lk_kind = 2'd0;
    logic            lk_hit;
    logic [PA_W-1:0] lk_paddr;
    logic            rf_valid = 1'b0;
    logic [VA_W-1:0] rf_vaddr = '0;
    logic [PA_W-1:0] rf_paddr = '0;
    logic [1:0]      rf_kind = 2'd0;
    logic            rf_uniform = 1'b0;
    logic            rf_trig = 1'b0;
    logic            mod_priv = 1'b0;
    logic            flush = 1'b0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_tlb uut (
        .clk(clk), .rst(rst),
        .lk_vaddr(lk_vaddr), .lk_kind(lk_kind), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
        .rf_valid(rf_valid), .rf_vaddr(rf_vaddr), .rf_paddr(rf_paddr), .rf_kind(rf_kind),
        .rf_uniform(rf_uniform), .rf_trig(rf_trig), .mod_priv(mod_priv), .flush(flush)
    );

    task automatic refill(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                          input logic [1:0] kind, input logic uni, input logic trig,
                          input logic with_flush);
        @(negedge clk);
        rf_vaddr = va; rf_paddr = pa; rf_kind = kind;
        rf_uniform = uni; rf_trig = trig; rf_valid = 1'b1; flush = with_flush;
        @(negedge clk);
        rf_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic look(input logic [VA_W-1:0] va, input logic [1:0] kind,
                        input logic exp_hit, input logic [PA_W-1:0] exp_pa,
                        input string req);
        lk_vaddr = va; lk_kind = kind;
        #1;
        n_run++;
        if (lk_hit !== exp_hit || lk_paddr !== (exp_hit ? exp_pa : '0)) begin
            n_fail++;
            $display("FAIL %s: va=%h kind=%0d got hit=%b pa=%h expected hit=%b pa=%h",
                     req, va, kind, lk_hit, lk_paddr, exp_hit, exp_hit ? exp_pa : '0);
        end
    endtask

    task automatic t_reset;
        look(32'h0000_1000, KF, 1'b0, '0, "R1");
        look(32'h0000_1000, KL, 1'b0, '0, "R1");
        look(32'hFFFF_F123, KS, 1'b0, '0, "R1");
        look(32'hFFFF_F123, KL, 1'b0, '0, "R1");
    endtask

    task automatic t_basic;
        refill(32'h1234_5000, 34'h2_ABCD_E000, KL, 1'b1, 1'b0, 1'b0);
        look(32'h1234_5ABC, KL, 1'b1, 34'h2_ABCD_EABC, "R2");
        look(32'h1234_5004, KL, 1'b1, 34'h2_ABCD_E004, "R2");
        look(32'h1234_5ABC, KF, 1'b0, '0, "R3");
        look(32'h1234_5ABC, KS, 1'b0, '0, "R3");
    endtask

    task automatic t_alias;
        look(32'h1244_5000, KL, 1'b0, '0, "R4");
        refill(32'h1244_5000, 34'h0_5555_5000, KF, 1'b1, 1'b0, 1'b0);
        look(32'h1234_5ABC, KL, 1'b0, '0, "R5");
        look(32'h1244_5010, KF, 1'b1, 34'h0_5555_5010, "R5");
        refill(32'h1244_5000, 34'h0_5555_5000, KS, 1'b1, 1'b0, 1'b0);
        look(32'h1244_5010, KF, 1'b1, 34'h0_5555_5010, "R5");
        look(32'h1244_5020, KS, 1'b1, 34'h0_5555_5020, "R5");
    endtask

    task automatic t_nonuniform;
        refill(32'h1244_5000, 34'h1_1111_1000, KL, 1'b0, 1'b0, 1'b0);
        look(32'h1244_5ABC, KL, 1'b0, '0, "R6");
        look(32'h1244_5ABC, KF, 1'b1, 34'h1_1111_1ABC, "R6");
        look(32'h1244_5ABC, KS, 1'b1, 34'h1_1111_1ABC, "R6");
    endtask

    task automatic t_trig;
        refill(32'h0000_3000, 34'h0_0000_7000, KF, 1'b1, 1'b1, 1'b0);
        look(32'h0000_3004, KF, 1'b0, '0, "R7");
        refill(32'h0000_4000, 34'h3_0000_8000, KL, 1'b1, 1'b1, 1'b0);
        look(32'h0000_4008, KL, 1'b1, 34'h3_0000_8008, "R7");
        refill(32'h0000_4000, 34'h3_0000_8000, KS, 1'b1, 1'b1, 1'b0);
        look(32'h0000_4010, KS, 1'b1, 34'h3_0000_8010, "R7");
        look(32'h0000_4008, KL, 1'b1, 34'h3_0000_8008, "R7");
    endtask

    task automatic t_override;
        @(negedge clk);
        mod_priv = 1'b1;
        refill(32'h0100_4000, 34'h0_0000_9000, KL, 1'b1, 1'b0, 1'b0);
        refill(32'h0000_5000, 34'h0_0000_9000, KS, 1'b1, 1'b0, 1'b0);
        mod_priv = 1'b0;
        look(32'h0100_4000, KL, 1'b0, '0, "R8");
        look(32'h0000_5000, KS, 1'b0, '0, "R8");
        look(32'h0000_4008, KL, 1'b1, 34'h3_0000_8008, "R8");
    endtask

    task automatic t_kind3;
        look(32'h0000_4008, KX, 1'b0, '0, "R10");
        refill(32'h0100_4000, 34'h0_0000_A000, KX, 1'b1, 1'b0, 1'b0);
        look(32'h0000_4008, KL, 1'b1, 34'h3_0000_8008, "R10");
        look(32'h0100_4000, KX, 1'b0, '0, "R10");
    endtask

    task automatic t_flush_collision;
        refill(32'h0000_6000, 34'h0_0000_B000, KL, 1'b1, 1'b0, 1'b1);
        look(32'h0000_6000, KL, 1'b0, '0, "R9");
        look(32'h0000_4008, KL, 1'b0, '0, "R9");
        look(32'h0000_4010, KS, 1'b0, '0, "R9");
        look(32'h1244_5ABC, KF, 1'b0, '0, "R9");
    endtask

    task automatic t_top_page;
        refill(32'hFFFF_F000, 34'h3_FFFF_F000, KL, 1'b1, 1'b0, 1'b0);
        look(32'hFFFF_F123, KL, 1'b1, 34'h3_FFFF_F123, "R2");
        look(32'hFFFF_F123, KS, 1'b0, '0, "R3");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_basic;
        t_alias;
        t_nonuniform;
        t_trig;
        t_override;
        t_kind3;
        t_flush_collision;
        t_top_page;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule